// File: doc/BRIEF.md
# Threshold Object Count Packer

The block collects candidate trigger objects over one bunch crossing and reports, for each object class, eta slice and region, how many of them cleared each of six programmable energy cuts. A candidate carries a class code, an eta index, a region code and a transverse-energy value. Every counter is two bits wide and stops at three. Once the crossing is closed, the block sends the counts out as 36 words of 12 bits, one word per accepted beat on a valid/ready output.

A crossing begins with a frame-start pulse, which clears every counter and copies the staged threshold values into the working set. Candidates then stream in on a valid/ready input. A frame-end pulse closes the crossing and starts the output phase. Each class has its own six thresholds. They are written one at a time through a plain write port into a staging copy, so a write never changes the cuts in the middle of a crossing.

Back-pressure rules: `cand_ready` is high only while a crossing is open. A candidate counts only in a cycle where both `cand_valid` and `cand_ready` are high. On the output side, a word presented with `out_valid` high stays unchanged until `out_ready` is seen high. The next word follows in the cycle after that handshake. The input is never ready while words are being sent.

Top module: `obj_count_packer`

## Requirements
- R1: After reset `out_valid` and `cand_ready` are 0, and every working and staged threshold is all ones. A crossing opened with no threshold writes therefore reports all-zero words.
- R2: An accepted candidate increments the counter for threshold k (1..6) of its class only when its energy is strictly greater than that class's working threshold k. Each threshold is judged on its own, and energy equal to a threshold does not count.
- R3: A counter that has reached 3 stays at 3 when further candidates pass its threshold.
- R4: In each output word the count for threshold k sits in bits 2k-1 down to 2k-2. Threshold 6 uses bits 11:10 and threshold 1 uses bits 1:0.
- R5: The output phase sends exactly 36 words. Word n holds class n/12, eta 2+(n%12)/3 and region n%3. Class codes are 0 = EM, 1 = jet, 2 = tau. Region codes are 0 = S, 1 = C, 2 = N.
- R6: A frame-start seen while idle clears every counter and raises `cand_ready` from the next cycle. A frame-start seen while a crossing is open or words are being sent has no effect.
- R7: A frame-end seen while a crossing is open lowers `cand_ready`. The first word appears with `out_valid` in the next cycle. A candidate accepted in the same cycle as the frame-end is included in the counts.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds. After the handshake on word 35 the block returns to idle, with `out_valid` and `cand_ready` both 0.
- R9: A candidate is not counted if any of these holds: eta outside 2..5, region code 3, class code 3, or `cand_ready` low.
- R10: A write with `cfg_we` high stores `cfg_value` in the staged copy of threshold `cfg_sel` (1..6) of class `cfg_type`. A write with `cfg_sel` of 0 or 7, or with `cfg_type` of 3, is ignored. The staged values become working values only at an accepted frame-start, and a write in that same cycle waits for the following crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Candidate present |
| cand_ready | output | 1 | Candidate accepted this cycle (crossing open) |
| cand_type | input | 2 | Object class code |
| cand_eta | input | 3 | Eta index |
| cand_region | input | 2 | Region code |
| cand_et | input | 10 | Transverse energy |
| frame_start | input | 1 | Opens a crossing |
| frame_end | input | 1 | Closes a crossing |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_type | input | 2 | Class of the threshold written |
| cfg_sel | input | 3 | Threshold number 1..6 |
| cfg_value | input | 10 | Threshold value |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 12 | Packed count word |

## Verification
Counting and closing a crossing can fall in the same cycle. The bench provokes this by sending a candidate together with each frame-end, and judges it by checking that the candidate shows up in the words that follow. A second overlap is a threshold write in the same cycle as the frame-start that loads the working set. This is judged by a candidate whose energy sits between the old and new values: it must follow the old value in that crossing and the new value in the next one. Output back-pressure is driven randomly during every drain, including a frame-start pulse sent in the middle of the word stream, which must be ignored.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_EMIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ocp_thr_bank.sv
module ocp_thr_bank #(
  parameter int N_TYPE = 3,
  parameter int N_THR  = 6,
  parameter int ET_W   = 10,
  parameter int TYPE_W = 2,
  parameter int SEL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [TYPE_W-1:0]             cfg_type,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [ET_W-1:0]               cfg_value,
  input  logic                          load,
  output logic [N_TYPE*N_THR*ET_W-1:0]  thr_flat
);
  localparam int N_ENT = N_TYPE * N_THR;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam logic [TYPE_W-1:0] T_CODE = TYPE_W'(e / N_THR);
    localparam logic [SEL_W-1:0]  S_CODE = SEL_W'((e % N_THR) + 1);
    logic [ET_W-1:0] staged;
    logic [ET_W-1:0] working;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged <= '1;
      end else if (cfg_we && cfg_type == T_CODE && cfg_sel == S_CODE) begin
        staged <= cfg_value;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        working <= '1;
      end else if (load) begin
        working <= staged;
      end
    end

    assign thr_flat[e*ET_W +: ET_W] = working;
  end
endmodule

// File: rtl/ocp_cnt_array.sv
module ocp_cnt_array #(
  parameter int N_TYPE   = 3,
  parameter int N_ETA    = 4,
  parameter int N_REG    = 3,
  parameter int N_THR    = 6,
  parameter int CNT_W    = 2,
  parameter int ET_W     = 10,
  parameter int TYPE_W   = 2,
  parameter int ETA_W    = 3,
  parameter int REG_W    = 2,
  parameter int ETA_BASE = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     clr,
  input  logic                                     acc,
  input  logic [TYPE_W-1:0]                        cand_type,
  input  logic [ETA_W-1:0]                         cand_eta,
  input  logic [REG_W-1:0]                         cand_reg,
  input  logic [ET_W-1:0]                          cand_et,
  input  logic [N_TYPE*N_THR*ET_W-1:0]             thr_flat,
  output logic [N_TYPE*N_ETA*N_REG*N_THR*CNT_W-1:0] cnt_flat
);
  localparam int CELLS_PER_TYPE = N_ETA * N_REG;
  localparam int N_CELL         = N_TYPE * CELLS_PER_TYPE;

  logic              in_range;
  int                cell_i;
  logic [N_CELL-1:0] hit;

  always_comb begin
    in_range = (int'(cand_type) < N_TYPE) &&
               (int'(cand_eta) >= ETA_BASE) &&
               (int'(cand_eta) < ETA_BASE + N_ETA) &&
               (int'(cand_reg) < N_REG);
    cell_i = int'(cand_type) * CELLS_PER_TYPE +
             (int'(cand_eta) - ETA_BASE) * N_REG + int'(cand_reg);
  end

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    localparam int TI = c / CELLS_PER_TYPE;
    assign hit[c] = acc && in_range && (cell_i == c);

    for (genvar j = 0; j < N_THR; j++) begin : g_thr
      logic [CNT_W-1:0] cnt;
      logic [ET_W-1:0]  cut;
      assign cut = thr_flat[(TI*N_THR + j)*ET_W +: ET_W];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (clr) begin
          cnt <= '0;
        end else if (hit[c] && (cand_et > cut) && (cnt != '1)) begin
          cnt <= cnt + 1'b1;
        end
      end

      assign cnt_flat[(c*N_THR + j)*CNT_W +: CNT_W] = cnt;
    end
  end
endmodule

// File: rtl/ocp_emit_seq.sv
module ocp_emit_seq
  import ocp_pkg::*;
#(
  parameter int N_WORDS = 36,
  parameter int IDX_W   = $clog2(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             out_ready,
  output logic             accum,
  output logic             start_take,
  output logic             out_valid,
  output logic [IDX_W-1:0] word_idx
);
  seq_state_t state;

  assign accum      = (state == ST_ACCUM);
  assign out_valid  = (state == ST_EMIT);
  assign start_take = (state == ST_IDLE) && frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      word_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (frame_start) state <= ST_ACCUM;
        ST_ACCUM: if (frame_end) begin
          state    <= ST_EMIT;
          word_idx <= '0;
        end
        ST_EMIT: if (out_ready) begin
          if (word_idx == IDX_W'(N_WORDS - 1)) begin
            state    <= ST_IDLE;
            word_idx <= '0;
          end else begin
            word_idx <= word_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/obj_count_packer.sv
module obj_count_packer #(
  parameter int ET_W     = 10,
  parameter int ETA_W    = 3,
  parameter int TYPE_W   = 2,
  parameter int REG_W    = 2,
  parameter int SEL_W    = 3,
  parameter int N_TYPE   = 3,
  parameter int N_ETA    = 4,
  parameter int N_REG    = 3,
  parameter int N_THR    = 6,
  parameter int CNT_W    = 2,
  parameter int ETA_BASE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cand_valid,
  output logic                    cand_ready,
  input  logic [TYPE_W-1:0]       cand_type,
  input  logic [ETA_W-1:0]        cand_eta,
  input  logic [REG_W-1:0]        cand_region,
  input  logic [ET_W-1:0]         cand_et,
  input  logic                    frame_start,
  input  logic                    frame_end,
  input  logic                    cfg_we,
  input  logic [TYPE_W-1:0]       cfg_type,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [ET_W-1:0]         cfg_value,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [N_THR*CNT_W-1:0]  out_data
);
  localparam int WORD_W  = N_THR * CNT_W;
  localparam int N_WORDS = N_TYPE * N_ETA * N_REG;
  localparam int IDX_W   = $clog2(N_WORDS);

  logic                          accum;
  logic                          start_take;
  logic [IDX_W-1:0]              word_idx;
  logic [N_TYPE*N_THR*ET_W-1:0]  thr_flat;
  logic [N_WORDS*WORD_W-1:0]     cnt_flat;

  assign cand_ready = accum;

  ocp_thr_bank #(
    .N_TYPE(N_TYPE), .N_THR(N_THR), .ET_W(ET_W), .TYPE_W(TYPE_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_type(cfg_type),
    .cfg_sel(cfg_sel), .cfg_value(cfg_value), .load(start_take),
    .thr_flat(thr_flat)
  );

  ocp_cnt_array #(
    .N_TYPE(N_TYPE), .N_ETA(N_ETA), .N_REG(N_REG), .N_THR(N_THR),
    .CNT_W(CNT_W), .ET_W(ET_W), .TYPE_W(TYPE_W), .ETA_W(ETA_W),
    .REG_W(REG_W), .ETA_BASE(ETA_BASE)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_take),
    .acc(cand_valid && accum), .cand_type(cand_type), .cand_eta(cand_eta),
    .cand_reg(cand_region), .cand_et(cand_et), .thr_flat(thr_flat),
    .cnt_flat(cnt_flat)
  );

  ocp_emit_seq #(
    .N_WORDS(N_WORDS), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_end(frame_end), .out_ready(out_ready), .accum(accum),
    .start_take(start_take), .out_valid(out_valid), .word_idx(word_idx)
  );

  always_comb begin
    out_data = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (word_idx == IDX_W'(w)) out_data = cnt_flat[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/obj_count_packer_chk.sv
module obj_count_packer_chk #(
  parameter int N_WORDS = 36,
  parameter int WORD_W  = 12,
  parameter int CNT_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cand_ready,
  input logic                      frame_start,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [WORD_W-1:0]         out_data,
  input logic [N_WORDS*WORD_W-1:0] cnt_flat
);
  localparam int N_FIELD = N_WORDS * WORD_W / CNT_W;
  localparam int BEAT_W  = $clog2(N_WORDS + 1);

  logic [BEAT_W-1:0] beats;

  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (cand_ready) beats <= '0;
    else if (out_valid && out_ready) beats <= beats + 1'b1;
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ready |-> !out_valid);

  a_r5_word_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> beats == BEAT_W'(N_WORDS));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !cand_ready && !out_valid |=> cnt_flat == '0);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_ready && !frame_start |=> $stable(cnt_flat));

  for (genvar f = 0; f < N_FIELD; f++) begin : g_sat
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[f*CNT_W +: CNT_W] == '1 && !frame_start
      |=> cnt_flat[f*CNT_W +: CNT_W] == '1);
  end
endmodule

bind obj_count_packer obj_count_packer_chk #(
  .N_WORDS(N_WORDS), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_ready(cand_ready),
  .frame_start(frame_start), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .cnt_flat(cnt_flat)
);

// File: tb/obj_count_packer_bench.sv
module obj_count_packer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cand_valid = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
  logic cfg_we = 1'b0, out_ready = 1'b0;
  logic [1:0] cand_type = '0, cand_region = '0, cfg_type = '0;
  logic [2:0] cand_eta = '0, cfg_sel = '0;
  logic [9:0] cand_et = '0, cfg_value = '0;
  logic cand_ready, out_valid;
  logic [11:0] out_data;

  always #5 clk = ~clk;

  obj_count_packer u_obj_count_packer (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_type(cand_type), .cand_eta(cand_eta), .cand_region(cand_region),
    .cand_et(cand_et), .frame_start(frame_start), .frame_end(frame_end),
    .cfg_we(cfg_we), .cfg_type(cfg_type), .cfg_sel(cfg_sel),
    .cfg_value(cfg_value), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int m_cnt [3][4][3][6];
  int m_stage [3][6];
  int m_work [3][6];
  int m_state = 0;   // 0 idle, 1 open, 2 sending
  int m_idx = 0;
  int got [36];

  task automatic check(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_word(int n);
    int t = n / 12, e = (n % 12) / 3, r = n % 3, w = 0;
    for (int j = 0; j < 6; j++) w |= m_cnt[t][e][r][j] << (2 * j);
    return w;
  endfunction

  task automatic step(bit v, int ty, int eta, int rg, int et,
                      bit fs, bit fe, bit we, int wty, int wsel, int wval);
    cand_valid = v; cand_type = 2'(ty); cand_eta = 3'(eta);
    cand_region = 2'(rg); cand_et = 10'(et);
    frame_start = fs; frame_end = fe;
    cfg_we = we; cfg_type = 2'(wty); cfg_sel = 3'(wsel); cfg_value = 10'(wval);
    @(posedge clk);
    if (m_state == 1 && v && ty < 3 && eta >= 2 && eta <= 5 && rg < 3)
      for (int j = 0; j < 6; j++)
        if (et > m_work[ty][j] && m_cnt[ty][eta-2][rg][j] < 3)
          m_cnt[ty][eta-2][rg][j]++;
    if (m_state == 0 && fs) begin
      foreach (m_cnt[a, b, c, d]) m_cnt[a][b][c][d] = 0;
      m_work = m_stage;
      m_state = 1;
    end else if (m_state == 1 && fe) begin
      m_state = 2; m_idx = 0;
    end
    if (we && wty < 3 && wsel >= 1 && wsel <= 6) m_stage[wty][wsel-1] = wval;
    @(negedge clk);
    cand_valid = 0; frame_start = 0; frame_end = 0; cfg_we = 0;
  endtask

  task automatic idle_cycle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(int ty, int sel, int val);
    step(0, 0, 0, 0, 0, 0, 0, 1, ty, sel, val);
  endtask

  task automatic drain(int inject_at);
    int beats = 0;
    check(cand_ready == 0, "R7 input closed while sending", cand_ready, 0);
    while (m_state == 2) begin
      out_ready = ($urandom_range(0, 3) != 0);
      frame_start = (beats == inject_at);
      check(out_valid == 1 && out_data == 12'(exp_word(m_idx)),
            "R5 word content/order", out_data, exp_word(m_idx));
      got[m_idx] = out_data;
      @(posedge clk);
      beats++;
      if (out_ready) begin
        if (m_idx == 35) m_state = 0; else m_idx++;
      end
      @(negedge clk);
      frame_start = 0;
    end
    out_ready = 0;
    check(out_valid == 0 && cand_ready == 0, "R8 idle after last word",
          {out_valid, cand_ready}, 0);
  endtask

  task automatic rand_frame(int ncand);
    for (int k = 0; k < 4; k++)
      wr($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 1023));
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check(cand_ready == 1, "R6 crossing open", cand_ready, 1);
    for (int k = 0; k < ncand; k++)
      step($urandom_range(0, 4) != 0, $urandom_range(0, 3), $urandom_range(0, 7),
           $urandom_range(0, 3), $urandom_range(0, 1023), 0, 0, 0, 0, 0, 0);
    step(1, $urandom_range(0, 2), $urandom_range(2, 5), $urandom_range(0, 2),
         1023, 0, 1, 0, 0, 0, 0);
    drain(-1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    foreach (m_stage[a, b]) begin m_stage[a][b] = 1023; m_work[a][b] = 1023; end
    repeat (3) @(negedge clk);
    check(out_valid == 0 && cand_ready == 0, "R1 reset outputs",
          {out_valid, cand_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && cand_ready == 0, "R1 idle after reset",
          {out_valid, cand_ready}, 0);

    // R1: reset thresholds pass nothing
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 2, 0, 1023, 0, 0, 0, 0, 0, 0);
    step(1, 1, 3, 1, 1023, 0, 1, 0, 0, 0, 0);
    drain(-1);
    check(got[0] == 0 && got[16] == 0, "R1 all-ones thresholds", got[16], 0);

    // R10: thresholds 100..600 for EM, plus ignored writes
    for (int j = 1; j <= 6; j++) wr(0, j, j * 100);
    wr(0, 0, 0); wr(0, 7, 0); wr(3, 1, 0);
    for (int j = 1; j <= 6; j++) wr(1, j, 50);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 2, 0, 350, 0, 0, 0, 0, 0, 0);         // R2: thr1..3
    step(1, 0, 2, 1, 300, 0, 0, 0, 0, 0, 0);         // R2: equal to thr3
    for (int k = 0; k < 5; k++) step(1, 0, 5, 2, 1000, 0, 0, 0, 0, 0, 0); // R3
    step(1, 0, 1, 0, 1000, 0, 0, 0, 0, 0, 0);        // R9 eta low
    step(1, 0, 6, 0, 1000, 0, 0, 0, 0, 0, 0);        // R9 eta high
    step(1, 0, 3, 3, 1000, 0, 0, 0, 0, 0, 0);        // R9 region 3
    step(1, 3, 3, 0, 1000, 0, 0, 0, 0, 0, 0);        // R9 class 3
    step(0, 0, 3, 0, 1000, 0, 0, 0, 0, 0, 0);        // no valid
    step(1, 1, 4, 1, 51, 0, 1, 0, 0, 0, 0);          // R7 with frame end
    drain(5);                                        // R6 ignored start
    check(got[0] == 12'h015, "R2/R4 strict compare and packing", got[0], 12'h015);
    check(got[1] == 12'h005, "R2 equal energy not counted", got[1], 12'h005);
    check(got[11] == 12'hFFF, "R3 saturation", got[11], 12'hFFF);
    check(got[19] == 12'h555, "R7 same-cycle candidate counted", got[19], 12'h555);
    check(got[3] == 0 && got[15] == 0, "R9 ignored candidates", got[15], 0);

    // R9 candidate while idle, R10 write with frame start waits a crossing
    step(1, 0, 2, 0, 1000, 0, 0, 0, 0, 0, 0);
    step(1, 0, 2, 0, 1000, 1, 0, 1, 0, 1, 0);
    step(1, 0, 3, 0, 50, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    drain(-1);
    check(got[0] == 0, "R9 idle candidate not counted", got[0], 0);
    check(got[3] == 0, "R10 same-cycle write deferred", got[3], 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 3, 0, 50, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    drain(-1);
    check(got[3] == 12'h001, "R10 write applied next crossing", got[3], 1);

    for (int f = 0; f < 6; f++) rand_frame($urandom_range(30, 80));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule